// File: doc/BRIEF.md
# Timed Trigger Wakeup Unit

This unit keeps the time base of a time-triggered communication coprocessor. A prescaler divides the core clock into scheduling ticks. With the default 100 MHz clock and `TICK_CYC` = 1000, one tick is 10 microseconds. The sequencer registers wake-up triggers, and each trigger is a relative delay in ticks plus a program address.

Up to `SLOTS` triggers (four by default) can be pending at once. Each pending trigger counts down on every tick. When it expires, the unit hands its resume address to the sequencer as a one-cycle pulse and frees the slot. A halt command holds the sequencer stalled until the next trigger is delivered. A trigger delivery is the only way out of the halt.

The unit also serves the wait for a round-synchronization event. A sync-wait command blocks until one of two things happens: a sync indication arrives from the receive path, or a timeout given in ticks elapses. Whichever comes first ends the wait. Every sync indication starts a new round, so it also realigns the tick prescaler. Rounds may therefore differ in length.

All pins are plain control and status. Commands are single-cycle strobes, and every cycle with a strobe high counts as one request. A request made when all slots are full is not held back. It is refused, and the refusal is flagged. The resume output has no ready and cannot be stalled. The sequencer must take the address in the cycle `resume_valid` is high.

Top module: `trig_wake_unit`

## Requirements
- R1: A tick is a cycle in which the prescaler is at its last count, and ticks repeat every `TICK_CYC` cycles. After reset is released, all outputs are low, and the first tick is the `TICK_CYC`-th cycle.
- R2: A request with delay d and address a accepted in cycle c makes `resume_valid` high, with `resume_addr` = a, in the second cycle after the (d+1)-th tick that falls strictly after cycle c.
- R3: A delay of zero fires on the first tick after acceptance. A tick in the same cycle as the acceptance is not counted.
- R4: A new trigger takes the lowest-numbered free slot. When several triggers expire on the same tick, the lowest slot is delivered first, and each of the others follows in its own consecutive cycle.
- R5: A request made while every slot is occupied is refused and changes no slot. `reg_refused` is high for exactly the next cycle.
- R6: Each delivery is a one-cycle `resume_valid` pulse that frees its slot for reuse.
- R7: `halted` rises in the cycle after `halt_cmd` and stays high until the cycle in which `resume_valid` goes high. A `halt_cmd` in the same cycle as a delivery still leaves the unit halted.
- R8: While `sync_waiting` is high, a `sync_rx` ends the wait. In the next cycle `sync_waiting` is low, `sync_done` is high and `sync_late` is low. A new `sync_wait_cmd` restarts the wait and takes priority over a `sync_rx` in the same cycle.
- R9: A wait with timeout t that sees no `sync_rx` ends on the (t+1)-th tick after the command. `sync_done` and `sync_late` are both high in the cycle after that tick.
- R10: A `sync_rx` in cycle c restarts the prescaler, so the next tick is cycle c+`TICK_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_req | input | 1 | Register-trigger strobe |
| reg_delay | input | DELAY_W | Relative delay in ticks |
| reg_addr | input | ADDR_W | Resume program address |
| halt_cmd | input | 1 | Halt strobe |
| sync_wait_cmd | input | 1 | Start a sync wait |
| sync_to | input | TO_W | Sync timeout in ticks, sampled with `sync_wait_cmd` |
| sync_rx | input | 1 | Sync indication pulse from the receive path |
| resume_valid | output | 1 | One-cycle pulse: a trigger expired |
| resume_addr | output | ADDR_W | Address to resume at, valid with `resume_valid` |
| reg_refused | output | 1 | Previous-cycle request refused because all slots were full |
| halted | output | 1 | Instruction issue held |
| sync_waiting | output | 1 | Sync wait in progress |
| sync_done | output | 1 | Sync wait ended this cycle |
| sync_late | output | 1 | With `sync_done`: the wait ended by timeout |

## Verification
The properties take for granted that every input is a known value once reset is released. They also assume `sync_to` and the request fields matter only in cycles where their strobes are high. No property assumes the strobes are spaced out, because the design treats each high cycle as a separate request. The stimulus therefore fires strobes at random densities, including back-to-back requests, requests into a full table, and halt or sync commands that coincide with deliveries and ticks. The prescaler is realigned with `sync_rx` before the directed cases that need two triggers to share a tick window.

// File: rtl/twu_pkg.sv
package twu_pkg;
  // Cause of the end of a sync wait, registered for one cycle
  typedef enum logic [1:0] {
    END_NONE = 2'd0,
    END_RX   = 2'd1,
    END_TO   = 2'd2
  } sync_end_e;
endpackage

// File: rtl/twu_tick_gen.sv
module twu_tick_gen #(
  parameter int TICK_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(TICK_CYC);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (restart || tick)  pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/twu_slot.sv
module twu_slot #(
  parameter int DELAY_W = 8,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DELAY_W-1:0] ld_delay,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic               tick,
  input  logic               take,
  output logic               busy,
  output logic               expired,
  output logic [ADDR_W-1:0]  addr
);
  logic [DELAY_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      expired <= 1'b0;
      rem_q   <= '0;
      addr    <= '0;
    end else if (take) begin
      busy    <= 1'b0;
      expired <= 1'b0;
    end else if (load) begin
      busy    <= 1'b1;
      expired <= 1'b0;
      rem_q   <= ld_delay;
      addr    <= ld_addr;
    end else if (tick && busy && !expired) begin
      if (rem_q == '0) expired <= 1'b1;
      else             rem_q   <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/twu_pick.sv
module twu_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] busy_vec,
  input  logic [N-1:0] exp_vec,
  input  logic         req,
  output logic [N-1:0] load_oh,
  output logic [N-1:0] take_oh,
  output logic         take_any,
  output logic         full
);
  logic free_found;
  logic exp_found;

  assign full     = &busy_vec;
  assign take_any = |exp_vec;

  always_comb begin
    load_oh    = '0;
    take_oh    = '0;
    free_found = 1'b0;
    exp_found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!free_found && !busy_vec[i]) begin
        free_found = 1'b1;
        load_oh[i] = req;
      end
      if (!exp_found && exp_vec[i]) begin
        exp_found  = 1'b1;
        take_oh[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/twu_sync_wait.sv
module twu_sync_wait
  import twu_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TO_W-1:0] to_val,
  input  logic            rx,
  input  logic            tick,
  output logic            waiting,
  output sync_end_e       cause
);
  logic [TO_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      rem_q   <= '0;
      cause   <= END_NONE;
    end else if (start) begin
      waiting <= 1'b1;
      rem_q   <= to_val;
      cause   <= END_NONE;
    end else if (waiting && rx) begin
      waiting <= 1'b0;
      cause   <= END_RX;
    end else if (waiting && tick && rem_q == '0) begin
      waiting <= 1'b0;
      cause   <= END_TO;
    end else begin
      if (waiting && tick) rem_q <= rem_q - 1'b1;
      cause <= END_NONE;
    end
  end
endmodule

// File: rtl/trig_wake_unit.sv
module trig_wake_unit
  import twu_pkg::*;
#(
  parameter int TICK_CYC = 1000,
  parameter int SLOTS    = 4,
  parameter int DELAY_W  = 8,
  parameter int ADDR_W   = 10,
  parameter int TO_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_req,
  input  logic [DELAY_W-1:0] reg_delay,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               halt_cmd,
  input  logic               sync_wait_cmd,
  input  logic [TO_W-1:0]    sync_to,
  input  logic               sync_rx,
  output logic               resume_valid,
  output logic [ADDR_W-1:0]  resume_addr,
  output logic               reg_refused,
  output logic               halted,
  output logic               sync_waiting,
  output logic               sync_done,
  output logic               sync_late
);
  logic              tick;
  logic [SLOTS-1:0]  busy_vec;
  logic [SLOTS-1:0]  exp_vec;
  logic [SLOTS-1:0]  load_oh;
  logic [SLOTS-1:0]  take_oh;
  logic              take_any;
  logic              full;
  logic [ADDR_W-1:0] slot_addr [SLOTS];
  logic [ADDR_W-1:0] pick_addr;
  sync_end_e         end_cause;

  twu_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(sync_rx), .tick(tick)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    twu_slot #(.DELAY_W(DELAY_W), .ADDR_W(ADDR_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(load_oh[g]), .ld_delay(reg_delay), .ld_addr(reg_addr),
      .tick(tick), .take(take_oh[g]),
      .busy(busy_vec[g]), .expired(exp_vec[g]), .addr(slot_addr[g])
    );
  end

  twu_pick #(.N(SLOTS)) u_pick (
    .busy_vec(busy_vec), .exp_vec(exp_vec), .req(reg_req),
    .load_oh(load_oh), .take_oh(take_oh), .take_any(take_any), .full(full)
  );

  twu_sync_wait #(.TO_W(TO_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .start(sync_wait_cmd), .to_val(sync_to),
    .rx(sync_rx), .tick(tick), .waiting(sync_waiting), .cause(end_cause)
  );

  assign sync_done = (end_cause != END_NONE);
  assign sync_late = (end_cause == END_TO);

  always_comb begin
    pick_addr = '0;
    for (int i = 0; i < SLOTS; i++)
      if (take_oh[i]) pick_addr = pick_addr | slot_addr[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_valid <= 1'b0;
      resume_addr  <= '0;
      reg_refused  <= 1'b0;
      halted       <= 1'b0;
    end else begin
      resume_valid <= take_any;
      if (take_any) resume_addr <= pick_addr;
      reg_refused  <= reg_req && full;
      if (halt_cmd)      halted <= 1'b1;
      else if (take_any) halted <= 1'b0;
    end
  end
endmodule

// File: rtl/twu_chk.sv
module twu_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_req,
  input logic         halt_cmd,
  input logic         sync_wait_cmd,
  input logic         sync_rx,
  input logic         resume_valid,
  input logic         reg_refused,
  input logic         halted,
  input logic         sync_waiting,
  input logic         sync_done,
  input logic         sync_late,
  input logic [N-1:0] busy_vec,
  input logic [N-1:0] exp_vec,
  input logic [N-1:0] take_oh
);
  // R5
  refuse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_refused |-> ($past(reg_req) && (&$past(busy_vec))));

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_oh));

  // R6
  resume_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |-> $past(|exp_vec));

  // R7
  halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> resume_valid);

  // R7
  halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt_cmd) |-> halted);

  // R8
  sync_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_waiting) |-> sync_done);

  // R8
  rx_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_waiting && sync_rx && !sync_wait_cmd) |=> (sync_done && !sync_late));

  // R9
  late_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_late |-> sync_done);
endmodule

bind trig_wake_unit twu_chk #(.N(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .halt_cmd(halt_cmd),
  .sync_wait_cmd(sync_wait_cmd), .sync_rx(sync_rx),
  .resume_valid(resume_valid), .reg_refused(reg_refused), .halted(halted),
  .sync_waiting(sync_waiting), .sync_done(sync_done), .sync_late(sync_late),
  .busy_vec(busy_vec), .exp_vec(exp_vec), .take_oh(take_oh)
);

// File: tb/trig_wake_unit_tb_top.sv
module trig_wake_unit_tb_top;
  localparam int TK = 16;
  localparam int NS = 4;
  localparam int DW = 8;
  localparam int AW = 10;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_req = 1'b0;
  logic [DW-1:0] reg_delay = '0;
  logic [AW-1:0] reg_addr = '0;
  logic halt_cmd = 1'b0, sync_wait_cmd = 1'b0, sync_rx = 1'b0;
  logic [TW-1:0] sync_to = '0;
  logic resume_valid, reg_refused, halted, sync_waiting, sync_done, sync_late;
  logic [AW-1:0] resume_addr;

  int vectors = 0, fails = 0;
  bit fin = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  trig_wake_unit #(.TICK_CYC(TK), .SLOTS(NS), .DELAY_W(DW), .ADDR_W(AW), .TO_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_delay(reg_delay),
    .reg_addr(reg_addr), .halt_cmd(halt_cmd), .sync_wait_cmd(sync_wait_cmd),
    .sync_to(sync_to), .sync_rx(sync_rx), .resume_valid(resume_valid),
    .resume_addr(resume_addr), .reg_refused(reg_refused), .halted(halted),
    .sync_waiting(sync_waiting), .sync_done(sync_done), .sync_late(sync_late)
  );

  // Reference model: trigger expiry by absolute tick index, per requirements
  int m_pre, m_ticks, m_to;
  bit m_busy[NS], m_exp[NS];
  int m_fire[NS];
  logic [AW-1:0] m_addr[NS];
  bit e_rv, e_ovf, e_halt, e_wait, e_done, e_late;
  logic [AW-1:0] e_ra;

  always @(posedge clk) begin
    bit tk;
    bit sb[NS];
    bit se[NS];
    int sel, fs;
    if (!rst_n) begin
      m_pre = 0; m_ticks = 0; m_to = 0;
      e_rv = 0; e_ovf = 0; e_halt = 0; e_wait = 0; e_done = 0; e_late = 0; e_ra = '0;
      for (int i = 0; i < NS; i++) begin m_busy[i] = 0; m_exp[i] = 0; m_fire[i] = 0; m_addr[i] = '0; end
    end else begin
      tk = (m_pre == TK - 1);
      for (int i = 0; i < NS; i++) begin sb[i] = m_busy[i]; se[i] = m_exp[i]; end
      sel = -1;
      for (int i = 0; i < NS; i++) if (sel < 0 && se[i]) sel = i;
      e_rv = (sel >= 0);
      if (sel >= 0) begin e_ra = m_addr[sel]; m_busy[sel] = 0; m_exp[sel] = 0; end
      if (tk)
        for (int i = 0; i < NS; i++)
          if (sb[i] && !se[i] && m_fire[i] == m_ticks) m_exp[i] = 1;
      e_ovf = 0;
      if (reg_req) begin
        fs = -1;
        for (int i = 0; i < NS; i++) if (fs < 0 && !sb[i]) fs = i;
        if (fs < 0) e_ovf = 1;
        else begin
          m_busy[fs] = 1; m_exp[fs] = 0; m_addr[fs] = reg_addr;
          m_fire[fs] = m_ticks + (tk ? 1 : 0) + int'(reg_delay);
        end
      end
      if (halt_cmd) e_halt = 1;
      else if (e_rv) e_halt = 0;
      e_done = 0; e_late = 0;
      if (sync_wait_cmd) begin
        e_wait = 1; m_to = m_ticks + (tk ? 1 : 0) + int'(sync_to);
      end else if (e_wait) begin
        if (sync_rx) begin e_wait = 0; e_done = 1; end
        else if (tk && m_ticks == m_to) begin e_wait = 0; e_done = 1; e_late = 1; end
      end
      if (tk) m_ticks++;
      m_pre = sync_rx ? 0 : (tk ? 0 : m_pre + 1);
    end
  end

  task automatic chk(string rq, string nm, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s act=%0h exp=%0h t=%0t", rq, phase, nm, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("R2", "resume_valid", 32'(resume_valid), 32'(e_rv));
    if (e_rv) chk("R4", "resume_addr", 32'(resume_addr), 32'(e_ra));
    chk("R5", "reg_refused", 32'(reg_refused), 32'(e_ovf));
    chk("R7", "halted", 32'(halted), 32'(e_halt));
    chk("R8", "sync_waiting", 32'(sync_waiting), 32'(e_wait));
    chk("R8", "sync_done", 32'(sync_done), 32'(e_done));
    chk("R9", "sync_late", 32'(sync_late), 32'(e_late));
    reg_req = 0; halt_cmd = 0; sync_wait_cmd = 0; sync_rx = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic req(int d, int a);
    reg_req = 1; reg_delay = DW'(d); reg_addr = AW'(a);
    cyc();
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    idle(3);                       // R1: reset state, all outputs low
    rst_n = 1;
    idle(2 * TK);                  // R1: idle after release
    phase = "R2";  req(2, 'h155); idle(4 * TK);
    phase = "R3";  req(0, 'h0AA); idle(2 * TK);
    phase = "R4";                  // same-tick expiry, lowest slot first
    sync_rx = 1; cyc();
    req(1, 'h011); req(1, 'h022); req(1, 'h033); idle(3 * TK);
    phase = "R5";                  // fill all slots, then one more
    for (int i = 0; i < NS; i++) req(5, 'h100 + i);
    req(1, 'h3FF); idle(7 * TK);
    phase = "R6";  req(0, 'h0F0); idle(2); req(2, 'h0F1); idle(4 * TK);
    phase = "R7";  halt_cmd = 1; cyc(); req(1, 'h077); idle(3 * TK);
    phase = "R8";  sync_wait_cmd = 1; sync_to = 5; cyc(); idle(10); sync_rx = 1; cyc(); idle(4);
    phase = "R9";  sync_wait_cmd = 1; sync_to = 1; cyc(); idle(3 * TK);
    phase = "R10"; idle(5); sync_rx = 1; cyc(); req(0, 'h2A2); idle(3 * TK);
    phase = "RND";
    for (int n = 0; n < 6000; n++) begin
      reg_req       = ($urandom % 64) < 7;
      reg_delay     = DW'($urandom % 6);
      reg_addr      = AW'($urandom);
      halt_cmd      = ($urandom % 40) == 0;
      sync_wait_cmd = ($urandom % 80) == 0;
      sync_to       = TW'($urandom % 4);
      sync_rx       = ($urandom % 120) == 0;
      cyc();
    end
    idle(8 * TK);
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!fin) begin
      fails++;
      $display("FAIL watchdog [%s] act=hung exp=finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule